// File: doc/BRIEF.md
# TLB-translated write-through cache access unit

This block accepts one 32-bit virtual load or store at a time. It translates the page number through a small fully associative translation buffer, checks per-page write permission, and then looks up a direct-mapped data cache of one-word lines. The cache is indexed by the physical address.

Each request ends in exactly one of three outcomes:

- a response, carrying read data for loads;
- a translation-miss exception;
- a write-protection exception.

Stores are written into the cache line and also pushed out on a write-buffer port (write-through). Read misses fetch the word through a refill handshake, and the block stalls while it waits. Software or a page walker outside the block loads translation entries through a fill port. A page dirty flag is kept per entry and reported with every response.

Top module: `tlbc_access_unit`

## Requirements
- R1: After reset, `req_ready` is 1 and `resp_valid`, `exc_tlb_miss`, `exc_wprot`, `stall`, `wb_valid` and `rf_req` are 0. All translation entries and all cache lines are invalid, so the first access to any page is a translation miss.
- R2: The physical address is the 18-bit page number of the matching entry in bits 29:12, followed by virtual bits 11:0 unchanged. It appears as `wb_addr` (30 bits) for stores and as `rf_addr` (physical bits 29:2) for refills.
- R3: A request that matches no valid entry raises `exc_tlb_miss` for one cycle, on the second rising edge after acceptance. No refill, no write-buffer push and no cache change follow.
- R4: A store whose matching entry has write permission 0 raises `exc_wprot` for one cycle, on the second edge after acceptance. The cache is left unchanged, so a later load of that address returns the old word.
- R5: A permitted store writes its data and tag into the indexed line. It then holds `wb_valid` with `wb_addr` and `wb_data` stable, and `stall` high, until `wb_ready` is sampled high. `resp_valid` follows on the next edge.
- R6: A load that hits returns `resp_rdata` with `resp_valid` on the second edge after acceptance, without raising `stall`.
- R7: A load that misses raises `stall` and pulses `rf_req` for one cycle. It waits for `rf_valid`, which may come one or more cycles later, then installs `rf_data` in the line and returns it with `resp_valid` on the next edge. A repeat load then hits.
- R8: A fill clears the entry's dirty flag and a permitted store sets it. `resp_dirty` reports the flag after the access: 1 for a store, and the entry's current flag for a load.
- R9: If a fill lands in the same cycle as a lookup, the lookup uses the entry as it was before the fill. If the fill targets the entry a store is marking dirty, the fill wins, so the entry ends with the new mapping and a clear dirty flag.
- R10: The cache index is physical bits 7:2 and the tag is physical bits 29:8. Byte-offset bits 1:0 are ignored on lookup. Two addresses with the same index and different tags evict each other.
- R11: A request is taken only in a cycle where `req_valid` and `req_ready` are both 1. `req_ready` is 0 from acceptance until the outcome is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_vaddr | input | 32 | Virtual byte address |
| req_wdata | input | 32 | Store data |
| resp_valid | output | 1 | Access completed (one-cycle pulse) |
| resp_rdata | output | 32 | Load data |
| resp_dirty | output | 1 | Page dirty flag after the access |
| stall | output | 1 | Waiting on refill or write buffer |
| exc_tlb_miss | output | 1 | Translation miss (one-cycle pulse) |
| exc_wprot | output | 1 | Write-protection fault (one-cycle pulse) |
| fill_en | input | 1 | Write a translation entry |
| fill_idx | input | 3 | Entry slot to write |
| fill_vpn | input | 20 | Virtual page number for the entry |
| fill_ppn | input | 18 | Physical page number for the entry |
| fill_wperm | input | 1 | Write permission for the page |
| fill_valid | input | 1 | Entry valid flag |
| wb_valid | output | 1 | Write-buffer entry offered |
| wb_ready | input | 1 | Write buffer accepts the entry |
| wb_addr | output | 30 | Physical byte address of the store |
| wb_data | output | 32 | Store data |
| rf_req | output | 1 | Refill request (one-cycle pulse) |
| rf_addr | output | 28 | Physical word address to refill |
| rf_valid | input | 1 | Refill word returned |
| rf_data | input | 32 | Refill word |

## Verification
The two functions that can fall in the same cycle are a translation fill arriving through the fill port and the lookup of a pending request, including the dirty update that a permitted store makes to the same entry. The bench provokes this by driving the fill port during the lookup cycle, right after a request is accepted, with the fill aimed at the slot the request hits. It judges the result twice. First, the store's `wb_addr` must still carry the old page number. Second, a following load must translate through the new page number and report `resp_dirty` 0. The same bench model also covers randomly mixed loads, stores, faults, refills with varying latency and write-buffer back-pressure.

// File: rtl/tlbc_pkg.sv
package tlbc_pkg;
    localparam int VA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = 18;
    localparam int PA_W   = PPN_W + OFF_W;
    localparam int BOFF_W = 2;
    localparam int WORD_W = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOK,
        ST_RFREQ,
        ST_RFWAIT,
        ST_WBUF
    } acc_state_e;

    typedef struct packed {
        logic             valid;
        logic             dirty;
        logic             wperm;
        logic [VPN_W-1:0] vpn;
        logic [PPN_W-1:0] ppn;
    } xlat_ent_t;

    function automatic logic [PA_W-1:0] make_pa(logic [PPN_W-1:0] ppn, logic [OFF_W-1:0] off);
        return {ppn, off};
    endfunction
endpackage

// File: rtl/tlbc_xlate.sv
module tlbc_xlate
    import tlbc_pkg::*;
#(
    parameter int ENTRIES = 8,
    localparam int IW = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             fill_en,
    input  logic [IW-1:0]    fill_idx,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PPN_W-1:0] fill_ppn,
    input  logic             fill_wperm,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] look_vpn,
    input  logic             set_dirty,
    output logic             hit,
    output logic [IW-1:0]    hit_idx,
    output logic [PPN_W-1:0] hit_ppn,
    output logic             hit_wperm,
    output logic             hit_dirty
);
    logic [ENTRIES-1:0] match;
    logic [ENTRIES-1:0] wperm_v;
    logic [ENTRIES-1:0] dirty_v;
    logic [PPN_W-1:0]   ppn_v [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        xlat_ent_t ent_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                ent_q <= '0;
            end else if (fill_en && fill_idx == IW'(g)) begin
                ent_q <= '{valid: fill_valid, dirty: 1'b0, wperm: fill_wperm,
                           vpn: fill_vpn, ppn: fill_ppn};
            end else if (set_dirty && hit_idx == IW'(g)) begin
                ent_q.dirty <= 1'b1;
            end
        end
        assign match[g]   = ent_q.valid && (ent_q.vpn == look_vpn);
        assign wperm_v[g] = ent_q.wperm;
        assign dirty_v[g] = ent_q.dirty;
        assign ppn_v[g]   = ent_q.ppn;
    end

    always_comb begin
        hit_idx = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (match[i]) hit_idx = IW'(i);
        end
    end

    assign hit       = |match;
    assign hit_ppn   = ppn_v[hit_idx];
    assign hit_wperm = wperm_v[hit_idx];
    assign hit_dirty = dirty_v[hit_idx];

    // R8
    dirty_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
        set_dirty |-> (hit && hit_wperm));
endmodule

// File: rtl/tlbc_dcache.sv
module tlbc_dcache
    import tlbc_pkg::*;
#(
    parameter int LINES = 64,
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = PA_W - IDX_W - BOFF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [IDX_W-1:0]  idx,
    input  logic [TAG_W-1:0]  tag,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              hit,
    output logic [WORD_W-1:0] rd_data
);
    logic [LINES-1:0]  valid_q;
    logic [TAG_W-1:0]  tag_q  [LINES];
    logic [WORD_W-1:0] data_q [LINES];

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[idx]  <= tag;
            data_q[idx] <= wr_data;
        end
    end

    assign hit     = valid_q[idx] && (tag_q[idx] == tag);
    assign rd_data = data_q[idx];

    // R5
    line_written_chk: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> valid_q[$past(idx)]);
endmodule

// File: rtl/tlbc_access_unit.sv
module tlbc_access_unit
    import tlbc_pkg::*;
#(
    parameter int TLB_N = 8,
    parameter int LINES = 64,
    localparam int TIW   = $clog2(TLB_N),
    localparam int IDX_W = $clog2(LINES),
    localparam int TAG_W = PA_W - IDX_W - BOFF_W
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic                   req_write,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic [WORD_W-1:0]      req_wdata,
    output logic                   resp_valid,
    output logic [WORD_W-1:0]      resp_rdata,
    output logic                   resp_dirty,
    output logic                   stall,
    output logic                   exc_tlb_miss,
    output logic                   exc_wprot,
    input  logic                   fill_en,
    input  logic [TIW-1:0]         fill_idx,
    input  logic [VPN_W-1:0]       fill_vpn,
    input  logic [PPN_W-1:0]       fill_ppn,
    input  logic                   fill_wperm,
    input  logic                   fill_valid,
    output logic                   wb_valid,
    input  logic                   wb_ready,
    output logic [PA_W-1:0]        wb_addr,
    output logic [WORD_W-1:0]      wb_data,
    output logic                   rf_req,
    output logic [PA_W-BOFF_W-1:0] rf_addr,
    input  logic                   rf_valid,
    input  logic [WORD_W-1:0]      rf_data
);
    acc_state_e        st_q;
    logic [VA_W-1:0]   va_q;
    logic              wr_q;
    logic [WORD_W-1:0] wd_q;
    logic [PA_W-1:0]   pa_q;
    logic              dirty_q;

    logic              t_hit, t_wperm, t_dirty;
    logic [TIW-1:0]    t_idx;
    logic [PPN_W-1:0]  t_ppn;
    logic              c_hit;
    logic [WORD_W-1:0] c_rdata;
    logic [PA_W-1:0]   pa_now, pa_sel;
    logic              look, st_ok, c_wr;

    assign look   = (st_q == ST_LOOK);
    assign st_ok  = look && t_hit && wr_q && t_wperm;
    assign pa_now = make_pa(t_ppn, va_q[OFF_W-1:0]);
    assign pa_sel = look ? pa_now : pa_q;
    assign c_wr   = st_ok || ((st_q == ST_RFWAIT) && rf_valid);

    tlbc_xlate #(.ENTRIES(TLB_N)) u_xlate (
        .clk(clk), .rst(rst),
        .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn),
        .fill_ppn(fill_ppn), .fill_wperm(fill_wperm), .fill_valid(fill_valid),
        .look_vpn(va_q[VA_W-1:OFF_W]), .set_dirty(st_ok),
        .hit(t_hit), .hit_idx(t_idx), .hit_ppn(t_ppn),
        .hit_wperm(t_wperm), .hit_dirty(t_dirty)
    );

    tlbc_dcache #(.LINES(LINES)) u_dcache (
        .clk(clk), .rst(rst),
        .idx(pa_sel[BOFF_W +: IDX_W]), .tag(pa_sel[PA_W-1 -: TAG_W]),
        .wr_en(c_wr), .wr_data((st_q == ST_RFWAIT) ? rf_data : wd_q),
        .hit(c_hit), .rd_data(c_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= ST_IDLE;
            va_q         <= '0;
            wr_q         <= 1'b0;
            wd_q         <= '0;
            pa_q         <= '0;
            dirty_q      <= 1'b0;
            resp_valid   <= 1'b0;
            resp_rdata   <= '0;
            resp_dirty   <= 1'b0;
            exc_tlb_miss <= 1'b0;
            exc_wprot    <= 1'b0;
        end else begin
            resp_valid   <= 1'b0;
            exc_tlb_miss <= 1'b0;
            exc_wprot    <= 1'b0;
            unique case (st_q)
                ST_IDLE: if (req_valid) begin
                    va_q <= req_vaddr;
                    wr_q <= req_write;
                    wd_q <= req_wdata;
                    st_q <= ST_LOOK;
                end
                ST_LOOK: begin
                    pa_q    <= pa_now;
                    dirty_q <= t_dirty;
                    if (!t_hit) begin
                        exc_tlb_miss <= 1'b1;
                        st_q         <= ST_IDLE;
                    end else if (wr_q && !t_wperm) begin
                        exc_wprot <= 1'b1;
                        st_q      <= ST_IDLE;
                    end else if (wr_q) begin
                        st_q <= ST_WBUF;
                    end else if (c_hit) begin
                        resp_valid <= 1'b1;
                        resp_rdata <= c_rdata;
                        resp_dirty <= t_dirty;
                        st_q       <= ST_IDLE;
                    end else begin
                        st_q <= ST_RFREQ;
                    end
                end
                ST_RFREQ: st_q <= ST_RFWAIT;
                ST_RFWAIT: if (rf_valid) begin
                    resp_valid <= 1'b1;
                    resp_rdata <= rf_data;
                    resp_dirty <= dirty_q;
                    st_q       <= ST_IDLE;
                end
                ST_WBUF: if (wb_ready) begin
                    resp_valid <= 1'b1;
                    resp_dirty <= 1'b1;
                    st_q       <= ST_IDLE;
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (st_q == ST_IDLE);
    assign stall     = (st_q == ST_RFREQ) || (st_q == ST_RFWAIT) || (st_q == ST_WBUF);
    assign wb_valid  = (st_q == ST_WBUF);
    assign wb_addr   = pa_q;
    assign wb_data   = wd_q;
    assign rf_req    = (st_q == ST_RFREQ);
    assign rf_addr   = pa_q[PA_W-1:BOFF_W];

    // R3
    one_outcome_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({resp_valid, exc_tlb_miss, exc_wprot}));
    // R5
    wb_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_addr) && $stable(wb_data)));
    // R5
    wb_stall_chk: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> stall);
    // R7
    rf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        rf_req |=> !rf_req);
    // R11
    outcome_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_valid || exc_tlb_miss || exc_wprot) |-> req_ready);
endmodule

// File: tb/tb_tlbc_access_unit.sv
module tb_tlbc_access_unit;
    localparam int CLK_PERIOD = 10;
    localparam logic [19:0] VB = 20'h4A000;

    logic        clk = 0, rst = 1;
    logic        req_valid = 0, req_write = 0;
    logic [31:0] req_vaddr = 0, req_wdata = 0;
    logic        req_ready, resp_valid, resp_dirty, stall, exc_tlb_miss, exc_wprot;
    logic [31:0] resp_rdata;
    logic        fill_en = 0, fill_wperm = 0, fill_valid = 0;
    logic [2:0]  fill_idx = 0;
    logic [19:0] fill_vpn = 0;
    logic [17:0] fill_ppn = 0;
    logic        wb_valid, wb_ready = 0;
    logic [29:0] wb_addr;
    logic [31:0] wb_data;
    logic        rf_req, rf_valid = 0;
    logic [27:0] rf_addr;
    logic [31:0] rf_data = 0;

    int checks = 0, errors = 0;

    bit          tv [8];
    bit          twp [8];
    bit          tdt [8];
    logic [19:0] tvpn [8];
    logic [17:0] tppn [8];
    bit          cv [64];
    logic [21:0] ctag [64];
    logic [31:0] cdat [64];
    logic [31:0] mem [int unsigned];

    tlbc_access_unit dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] mem_rd(logic [27:0] wa);
        if (mem.exists(int'(wa))) return mem[int'(wa)];
        return {4'h0, wa} * 32'h9E3779B1 ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(bit ok, string r, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %h expected %h", r, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic do_fill(int i, logic [19:0] v, logic [17:0] p, bit wp, bit val);
        @(negedge clk);
        fill_en = 1; fill_idx = 3'(i); fill_vpn = v; fill_ppn = p;
        fill_wperm = wp; fill_valid = val;
        @(posedge clk);
        @(negedge clk);
        fill_en = 0;
        tv[i] = val; twp[i] = wp; tdt[i] = 0; tvpn[i] = v; tppn[i] = p;
    endtask

    task automatic run_req(bit wr, logic [31:0] va, logic [31:0] wd, int hold,
                           bit cf, int fi, logic [19:0] fv, logic [17:0] fp, bit fw);
        int e, ix, kind, cyc, rf_cnt, wbh;
        bit cmiss, got, saw_rf, saw_wb, rf_pend;
        logic [29:0] pa;
        logic [21:0] tg;
        logic [31:0] exp_d;
        bit exp_dirty;
        e = -1;
        for (int i = 0; i < 8; i++) if (e < 0 && tv[i] && tvpn[i] == va[31:12]) e = i;
        if (e < 0) kind = 1; else if (wr && !twp[e]) kind = 2; else kind = 0;
        pa = (e >= 0) ? {tppn[e], va[11:0]} : '0;
        ix = int'(pa[7:2]); tg = pa[29:8];
        cmiss = !(cv[ix] && ctag[ix] == tg);
        exp_d = cmiss ? mem_rd(pa[29:2]) : cdat[ix];
        exp_dirty = wr ? 1'b1 : ((e >= 0) ? tdt[e] : 1'b0);
        while (!req_ready) @(negedge clk);
        req_valid = 1; req_write = wr; req_vaddr = va; req_wdata = wd;
        @(posedge clk);
        @(negedge clk);
        req_valid = 0;
        chk(!req_ready, "R11 ready low while busy", 64'(req_ready), 64'd0);
        if (cf) begin
            fill_en = 1; fill_idx = 3'(fi); fill_vpn = fv; fill_ppn = fp;
            fill_wperm = fw; fill_valid = 1;
        end
        got = 0; cyc = 0; saw_rf = 0; saw_wb = 0; rf_pend = 0; rf_cnt = 0; wbh = hold;
        while (!got && cyc < 60) begin
            @(negedge clk);
            cyc++;
            fill_en = 0;
            rf_valid = 0;
            if (rf_pend) begin
                if (rf_cnt == 0) begin
                    rf_valid = 1; rf_data = mem_rd(pa[29:2]); rf_pend = 0;
                end else rf_cnt--;
            end
            if (rf_req) begin
                saw_rf = 1; rf_pend = 1; rf_cnt = int'($urandom % 3);
                chk(rf_addr == pa[29:2], "R2 refill word address", 64'(rf_addr), 64'(pa[29:2]));
                chk(stall, "R7 stall during refill", 64'(stall), 64'd1);
            end
            if (wb_valid) begin
                if (!saw_wb) begin
                    chk(wb_addr == pa, "R2 write-buffer address", 64'(wb_addr), 64'(pa));
                    chk(wb_data == wd, "R5 write-buffer data", 64'(wb_data), 64'(wd));
                end else begin
                    chk(wb_addr == pa && wb_data == wd, "R5 held entry stable",
                        {wb_addr, wb_data[31:0]}, {pa, wd});
                end
                chk(stall, "R5 stall while buffer busy", 64'(stall), 64'd1);
                saw_wb = 1;
                if (wbh > 0) begin wb_ready = 0; wbh--; end else wb_ready = 1;
            end else wb_ready = 0;
            if (resp_valid || exc_tlb_miss || exc_wprot) got = 1;
        end
        rf_valid = 0; wb_ready = 0;
        if (!got) chk(0, "R11 request timed out", 64'(cyc), 64'd0);
        case (kind)
            1: begin
                chk(exc_tlb_miss && !resp_valid && !exc_wprot, "R3 translation miss",
                    {exc_tlb_miss, resp_valid, exc_wprot}, 64'b100);
                chk(cyc == 1 && !saw_rf && !saw_wb, "R3 timing and no side effect",
                    {cyc, saw_rf, saw_wb}, {32'd1, 2'b00});
            end
            2: begin
                chk(exc_wprot && !resp_valid && !exc_tlb_miss, "R4 write protection",
                    {exc_wprot, resp_valid, exc_tlb_miss}, 64'b100);
                chk(cyc == 1 && !saw_rf && !saw_wb, "R4 timing and no side effect",
                    {cyc, saw_rf, saw_wb}, {32'd1, 2'b00});
            end
            default: begin
                chk(resp_valid && !exc_tlb_miss && !exc_wprot, wr ? "R5 store response" : "R6 load response",
                    {resp_valid, exc_tlb_miss, exc_wprot}, 64'b100);
                chk(resp_dirty == exp_dirty, "R8 dirty flag", 64'(resp_dirty), 64'(exp_dirty));
                if (wr) begin
                    chk(saw_wb && !saw_rf, "R5 store pushed, no refill", {saw_wb, saw_rf}, 64'b10);
                end else begin
                    chk(resp_rdata == exp_d, cmiss ? "R7 refill data" : "R6 hit data",
                        64'(resp_rdata), 64'(exp_d));
                    chk(saw_rf == cmiss, "R10 hit/miss by index and tag", 64'(saw_rf), 64'(cmiss));
                    if (!cmiss) chk(cyc == 1, "R6 hit latency", 64'(cyc), 64'd1);
                end
            end
        endcase
        if (kind == 0) begin
            if (wr) begin
                cv[ix] = 1; ctag[ix] = tg; cdat[ix] = wd;
                mem[int'(pa[29:2])] = wd; tdt[e] = 1;
            end else if (cmiss) begin
                cv[ix] = 1; ctag[ix] = tg; cdat[ix] = exp_d;
            end
        end
        if (cf) begin
            tv[fi] = 1; twp[fi] = fw; tdt[fi] = 0; tvpn[fi] = fv; tppn[fi] = fp;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "R11 watchdog expired", 64'd0, 64'd1);
        summary();
        $finish;
    end

    initial begin
        logic [17:0] ppool [4];
        void'($urandom(32'd1234));
        ppool[0] = 18'h00003; ppool[1] = 18'h3FFFF; ppool[2] = 18'h12345; ppool[3] = 18'h00000;
        for (int i = 0; i < 8; i++) begin tv[i] = 0; twp[i] = 0; tdt[i] = 0; tvpn[i] = 0; tppn[i] = 0; end
        for (int i = 0; i < 64; i++) begin cv[i] = 0; ctag[i] = 0; cdat[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk(req_ready && !resp_valid && !exc_tlb_miss && !exc_wprot && !stall && !wb_valid && !rf_req,
            "R1 reset outputs",
            {req_ready, resp_valid, exc_tlb_miss, exc_wprot, stall, wb_valid, rf_req}, 64'b1000000);
        // R1: every entry invalid -> translation miss
        run_req(0, {VB, 12'h040}, 0, 0, 0, 0, 0, 0, 0);
        // R7 miss then R6 hit, R8 dirty clear after fill
        do_fill(0, VB, 18'h00003, 1, 1);
        run_req(0, {VB, 12'h044}, 0, 0, 0, 0, 0, 0, 0);
        run_req(0, {VB, 12'h047}, 0, 0, 0, 0, 0, 0, 0);
        // R4 protected store leaves line intact
        do_fill(1, VB + 20'd1, 18'h3FFFF, 0, 1);
        run_req(0, {VB + 20'd1, 12'h100}, 0, 0, 0, 0, 0, 0, 0);
        run_req(1, {VB + 20'd1, 12'h100}, 32'hDEADBEEF, 0, 0, 0, 0, 0, 0);
        run_req(0, {VB + 20'd1, 12'h100}, 0, 0, 0, 0, 0, 0, 0);
        // R5 store with back-pressure, R8 dirty set
        run_req(1, {VB, 12'h044}, 32'hCAFE0001, 4, 0, 0, 0, 0, 0);
        run_req(0, {VB, 12'h044}, 0, 0, 0, 0, 0, 0, 0);
        // R10 conflict: same index, other tag
        run_req(0, {VB, 12'h144}, 0, 0, 0, 0, 0, 0, 0);
        run_req(0, {VB, 12'h044}, 0, 0, 0, 0, 0, 0, 0);
        // R9 fill during lookup of a store to the same slot
        do_fill(2, VB + 20'd2, 18'h00010, 1, 1);
        run_req(1, {VB + 20'd2, 12'h208}, 32'h0BADF00D, 1, 1, 2, VB + 20'd2, 18'h00020, 1);
        run_req(0, {VB + 20'd2, 12'h208}, 0, 0, 0, 0, 0, 0, 0);
        // constrained random mix
        for (int n = 0; n < 600; n++) begin
            int k, sel;
            logic [31:0] va;
            sel = int'($urandom % 10);
            if (sel == 0) begin
                k = int'($urandom % 16);
                do_fill(k % 8, VB + 20'(k), ppool[$urandom % 4], 1'($urandom % 2), 1'($urandom % 8 != 0));
            end else begin
                k = int'($urandom % 16);
                va = {VB + 20'(k), 2'b00, 2'($urandom % 2), 2'b00, 4'($urandom % 4), 2'($urandom % 4)};
                run_req(1'($urandom % 3 == 0), va, $urandom, int'($urandom % 4), 0, 0, 0, 0, 0);
            end
        end
        summary();
        $finish;
    end
endmodule